// File: doc/BRIEF.md
# Page Referenced/Changed Bit Updater

This unit decides, once a memory access has completed, whether the referenced (R) and changed (C) bits of the page it touched must be set. The caller presents an access descriptor. It holds a set of scenario flags, the R and C bits already cached in the translation buffer entry, and the address of the page table entry word. A fixed priority order reduces the flags to a single outcome. The outcome is "no bits", "R only" or "R and C". Speculative work, zero-length string moves and faulting accesses can each set fewer bits than a plain access would.

If the outcome needs a bit that the cached copy lacks, the unit runs a read-modify-write of the page table entry word over a simple request/response memory port. It ORs in only the missing bits. It then reports the new R/C state so that the translation buffer copy can be updated. If nothing is missing, no memory traffic is issued. The unit handles one access at a time.

Top module: `rc_bit_updater`

## Requirements
- R1: Scenario flags are resolved by priority: flag bit 0 is highest and bit 10 lowest. Only the lowest-numbered flag that is set decides the outcome, whatever the other flags are.
- R2: Flag bit 0 (no-execute protection fault) yields no bits to set.
- R3: Flag bit 1 (page protection fault) yields R only. This holds even when flag bit 7 (failed conditional store) is also set.
- R4: Flag bits 2 (speculative fetch or load), 3 (speculative store waiting on a branch, trap, system call, interrupt return or possible exception) and 4 (speculative store waiting on an exception that does not occur) yield no bits.
- R5: Flag bits 5 (zero-length string load) and 6 (zero-length string store) yield no bits.
- R6: Flag bit 7 (conditional store that did not store) yields R and C.
- R7: Flag bits 8 (in-order fetch) and 9 (load-class access) yield R only. Flag bit 10 (store-class access, including block zero) yields R and C. No flag set yields no bits.
- R8: An access is taken when `acc_valid` is high and `busy` is low. If the cached R/C bits already cover the outcome, no memory request is issued. `done` is then high for one cycle in the cycle after acceptance, with `tlb_set_valid` low.
- R9: Otherwise the unit issues a read and then a write to `acc_pte_addr`. The write data is the read word ORed with only the missing bits, R at bit 8 and C at bit 7. A request holds its address and direction until `mem_req_ready`.
- R10: Every memory request carries `mem_req_attr` = 4'b1100. In that code bit 0 is translation-enable (0), bit 1 guarded (0), bit 2 cacheable (1) and bit 3 coherent (1).
- R11: `busy` is high from the cycle after acceptance until the write response. In the following cycle `done` and `tlb_set_valid` are high for one cycle. `tlb_set_r`/`tlb_set_c` then equal the cached bits ORed with the outcome, and `busy` is low. `acc_valid` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access descriptor present |
| acc_flags | input | 11 | Scenario flags, bit 0 highest priority |
| acc_tlb_r | input | 1 | Cached referenced bit |
| acc_tlb_c | input | 1 | Cached changed bit |
| acc_pte_addr | input | 8 | Page table entry word address |
| busy | output | 1 | Update in progress; new accesses ignored |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 8 | Request address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_attr | output | 4 | Access attributes (R10 encoding) |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Response (read data or write ack) |
| mem_rsp_rdata | input | 32 | Read data |
| tlb_set_valid | output | 1 | Update cached R/C bits |
| tlb_set_r | output | 1 | New referenced bit |
| tlb_set_c | output | 1 | New changed bit |
| done | output | 1 | Access finished |

## Verification
The corner that is hardest to reach is a collision of scenarios. A single access carries a high-priority flag together with every lower one, for example a protection fault on a conditional store that also failed. The sweep walks each flag as the winning one, alone and with all lower-priority flags set, against all four cached R/C states. This reaches both the skip path and every mix of missing bits. A memory model whose ready toggles each cycle stalls requests partway through. A second descriptor is also pulsed while an update is in flight.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

   localparam int unsigned SCN_COUNT = 11;

   // index of each scenario flag; lower index wins
   localparam int unsigned SCN_NX_FAULT   = 0;
   localparam int unsigned SCN_PROT_FAULT = 1;
   localparam int unsigned SCN_SPEC_LOAD  = 2;
   localparam int unsigned SCN_SPEC_ST_CF = 3;
   localparam int unsigned SCN_SPEC_ST_EX = 4;
   localparam int unsigned SCN_ZLEN_LOAD  = 5;
   localparam int unsigned SCN_ZLEN_STORE = 6;
   localparam int unsigned SCN_STC_FAIL   = 7;
   localparam int unsigned SCN_FETCH      = 8;
   localparam int unsigned SCN_LOAD       = 9;
   localparam int unsigned SCN_STORE      = 10;

   // translation-enable, guarded, cacheable, coherent (bit 0 .. bit 3)
   localparam logic [3:0] RMW_ATTR = 4'b1100;

   typedef struct packed {
      logic r;
      logic c;
   } rc_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_WR_REQ,
      ST_WR_WAIT
   } rmw_state_t;

   function automatic rc_t scn_outcome(input int unsigned idx);
      rc_t o;
      o = '{r: 1'b0, c: 1'b0};
      case (idx)
         SCN_PROT_FAULT: o = '{r: 1'b1, c: 1'b0};
         SCN_STC_FAIL:   o = '{r: 1'b1, c: 1'b1};
         SCN_FETCH:      o = '{r: 1'b1, c: 1'b0};
         SCN_LOAD:       o = '{r: 1'b1, c: 1'b0};
         SCN_STORE:      o = '{r: 1'b1, c: 1'b1};
         default:        o = '{r: 1'b0, c: 1'b0};
      endcase
      return o;
   endfunction

endpackage

// File: rtl/rcu_prio_resolver.sv
module rcu_prio_resolver
   import rcu_pkg::*;
(
   input  logic [SCN_COUNT-1:0] flags,
   output rc_t                  need
);

   function automatic logic [SCN_COUNT-1:0] build_mask(input bit pick_c);
      logic [SCN_COUNT-1:0] m;
      rc_t o;
      m = '0;
      for (int unsigned i = 0; i < SCN_COUNT; i++) begin
         o = scn_outcome(i);
         m[i] = pick_c ? o.c : o.r;
      end
      return m;
   endfunction

   localparam logic [SCN_COUNT-1:0] R_MASK = build_mask(1'b0);
   localparam logic [SCN_COUNT-1:0] C_MASK = build_mask(1'b1);

   logic [SCN_COUNT-1:0] win;

   genvar gi;
   generate
      for (gi = 0; gi < SCN_COUNT; gi++) begin : g_win
         if (gi == 0) begin : g_top
            assign win[gi] = flags[gi];
         end else begin : g_rest
            assign win[gi] = flags[gi] & ~(|flags[gi-1:0]);
         end
      end
   endgenerate

   assign need.r = |(win & R_MASK);
   assign need.c = |(win & C_MASK);

   always_comb begin
      // R1
      single_winner_chk: assert ($onehot0(win))
         else $error("more than one scenario won");
      // R7
      c_implies_r_chk: assert (!need.c || need.r)
         else $error("changed bit requested without referenced bit");
      // R1
      winner_present_chk: assert ((flags == '0) || (win != '0))
         else $error("flags set but no winner");
   end

endmodule

// File: rtl/rcu_rmw_engine.sv
module rcu_rmw_engine
   import rcu_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned R_POS  = 8,
   parameter int unsigned C_POS  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  rc_t               missing,
   input  rc_t               final_rc,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              busy,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   output logic [3:0]        mem_req_attr,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic              tlb_set_valid,
   output rc_t               tlb_set,
   output logic              done
);

   localparam logic [DATA_W-1:0] R_BIT_MASK = DATA_W'(1) << R_POS;
   localparam logic [DATA_W-1:0] C_BIT_MASK = DATA_W'(1) << C_POS;

   rmw_state_t        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] word_q;
   rc_t               final_q;
   logic              done_q;
   logic              tlbv_q;

   logic [DATA_W-1:0] new_mask;
   assign new_mask = (missing.r ? R_BIT_MASK : '0) | (missing.c ? C_BIT_MASK : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         mask_q  <= '0;
         word_q  <= '0;
         final_q <= '{r: 1'b0, c: 1'b0};
         done_q  <= 1'b0;
         tlbv_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         tlbv_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q  <= addr_in;
                  mask_q  <= new_mask;
                  final_q <= final_rc;
                  if (new_mask != '0) begin
                     state_q <= ST_RD_REQ;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            ST_RD_REQ: begin
               if (mem_req_ready) state_q <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (mem_rsp_valid) begin
                  word_q  <= mem_rsp_rdata;
                  state_q <= ST_WR_REQ;
               end
            end
            ST_WR_REQ: begin
               if (mem_req_ready) state_q <= ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
               if (mem_rsp_valid) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  tlbv_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
   assign mem_req_write = (state_q == ST_WR_REQ);
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = word_q | mask_q;
   assign mem_req_attr  = RMW_ATTR;
   assign tlb_set_valid = tlbv_q;
   assign tlb_set       = final_q;
   assign done          = done_q;

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

   // R9
   read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (mem_req_valid && !mem_req_write));

   // R11
   tlb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_set_valid |-> (done && !busy));

   // R11
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && tlb_set_valid));

endmodule

// File: rtl/rc_bit_updater.sv
module rc_bit_updater
   import rcu_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned R_POS      = 8,
   parameter int unsigned C_POS      = 7,
   parameter bit          TLB_FILTER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic [SCN_COUNT-1:0] acc_flags,
   input  logic                 acc_tlb_r,
   input  logic                 acc_tlb_c,
   input  logic [ADDR_W-1:0]    acc_pte_addr,
   output logic                 busy,
   output logic                 mem_req_valid,
   output logic                 mem_req_write,
   output logic [ADDR_W-1:0]    mem_req_addr,
   output logic [DATA_W-1:0]    mem_req_wdata,
   output logic [3:0]           mem_req_attr,
   input  logic                 mem_req_ready,
   input  logic                 mem_rsp_valid,
   input  logic [DATA_W-1:0]    mem_rsp_rdata,
   output logic                 tlb_set_valid,
   output logic                 tlb_set_r,
   output logic                 tlb_set_c,
   output logic                 done
);

   generate
      if (R_POS >= DATA_W || C_POS >= DATA_W || R_POS == C_POS) begin : g_bad_bits
         $error("R/C bit positions must be distinct and inside the data word");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address width must be at least one bit");
      end
   endgenerate

   rc_t  need;
   rc_t  cached;
   rc_t  missing;
   rc_t  final_rc;
   rc_t  tlb_set;
   logic accept;

   assign cached   = '{r: acc_tlb_r, c: acc_tlb_c};
   assign accept   = acc_valid && !busy;
   assign final_rc = '{r: cached.r | need.r, c: cached.c | need.c};

   rcu_prio_resolver u_resolver (
      .flags (acc_flags),
      .need  (need)
   );

   generate
      if (TLB_FILTER) begin : g_filtered
         assign missing = '{r: need.r & ~cached.r, c: need.c & ~cached.c};
      end else begin : g_always
         assign missing = need;
      end
   endgenerate

   rcu_rmw_engine #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .R_POS  (R_POS),
      .C_POS  (C_POS)
   ) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept        (accept),
      .missing       (missing),
      .final_rc      (final_rc),
      .addr_in       (acc_pte_addr),
      .busy          (busy),
      .mem_req_valid (mem_req_valid),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_req_attr  (mem_req_attr),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_rdata (mem_rsp_rdata),
      .tlb_set_valid (tlb_set_valid),
      .tlb_set       (tlb_set),
      .done          (done)
   );

   assign tlb_set_r = tlb_set.r;
   assign tlb_set_c = tlb_set.c;

   // R10
   attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_attr == 4'b1100));

   // R11
   write_sets_tlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_set_valid |-> tlb_set_r);

endmodule

// File: tb/rc_bit_updater_test.sv
module rc_bit_updater_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [10:0] acc_flags = '0;
   logic        acc_tlb_r = 1'b0;
   logic        acc_tlb_c = 1'b0;
   logic [7:0]  acc_pte_addr = '0;
   logic        busy, mem_req_valid, mem_req_write;
   logic [7:0]  mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic [3:0]  mem_req_attr;
   logic        mem_req_ready;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_rdata;
   logic        tlb_set_valid, tlb_set_r, tlb_set_c, done;

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int done_cnt = 0;
   int attr_bad = 0;
   logic [31:0] mem [16];

   always #10 clk = ~clk;

   rc_bit_updater uut (
      .clk (clk), .rst_n (rst_n),
      .acc_valid (acc_valid), .acc_flags (acc_flags),
      .acc_tlb_r (acc_tlb_r), .acc_tlb_c (acc_tlb_c),
      .acc_pte_addr (acc_pte_addr), .busy (busy),
      .mem_req_valid (mem_req_valid), .mem_req_write (mem_req_write),
      .mem_req_addr (mem_req_addr), .mem_req_wdata (mem_req_wdata),
      .mem_req_attr (mem_req_attr), .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid), .mem_rsp_rdata (mem_rsp_rdata),
      .tlb_set_valid (tlb_set_valid), .tlb_set_r (tlb_set_r),
      .tlb_set_c (tlb_set_c), .done (done)
   );

   // memory model: ready toggles, response one cycle after handshake
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req_ready <= 1'b0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_rdata <= '0;
         for (int i = 0; i < 16; i++) mem[i] <= 32'h5A5A_3C00 ^ (32'h0001_1111 * i) ^ 32'h0000_0031;
      end else begin
         mem_req_ready <= ~mem_req_ready;
         mem_rsp_valid <= 1'b0;
         if (done) done_cnt <= done_cnt + 1;
         if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            if (mem_req_attr != 4'b1100) attr_bad <= attr_bad + 1;
            if (mem_req_write) begin
               mem[mem_req_addr[3:0]] <= mem_req_wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               mem_rsp_rdata <= mem[mem_req_addr[3:0]];
               rd_cnt <= rd_cnt + 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // expected outcome {r,c}, lowest set flag wins (R1..R7)
   function automatic logic [1:0] exp_rc(input logic [10:0] f);
      for (int i = 0; i < 11; i++) begin
         if (f[i]) begin
            case (i)
               1, 8, 9: return 2'b10;
               7, 10:   return 2'b11;
               default: return 2'b00;
            endcase
         end
      end
      return 2'b00;
   endfunction

   function automatic string req_of(input int k);
      case (k)
         0: return "R2";
         1: return "R3";
         2, 3, 4: return "R4";
         5, 6: return "R5";
         7: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic run_access(input logic [10:0] f, input logic [1:0] crc,
                             input logic [3:0] a, input string req);
      logic [1:0]  need, miss, fin;
      logic [31:0] old_word, exp_word;
      int          rd0, wr0, waited;
      need = exp_rc(f);
      miss = need & ~crc;
      fin  = need | crc;
      old_word = mem[a];
      exp_word = old_word | (miss[1] ? 32'h100 : 32'h0) | (miss[0] ? 32'h80 : 32'h0);
      rd0 = rd_cnt;
      wr0 = wr_cnt;
      @(negedge clk);
      acc_flags = f; acc_tlb_r = crc[1]; acc_tlb_c = crc[0];
      acc_pte_addr = {4'h0, a}; acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0;
      if (miss == 2'b00) begin
         // R8 skip path
         check(done && !tlb_set_valid && !busy, req, "R8 skip done/tlbv/busy",
               {29'b0, done, tlb_set_valid, busy}, 32'h4);
         repeat (3) @(negedge clk);
         check(rd_cnt == rd0 && wr_cnt == wr0, req, "R8 no memory traffic",
               32'(rd_cnt - rd0 + wr_cnt - wr0), 32'h0);
      end else begin
         check(busy == 1'b1, req, "R11 busy after accept", {31'b0, busy}, 32'h1);
         waited = 0;
         while (!done && waited < 60) begin
            @(negedge clk);
            waited++;
         end
         check(done && tlb_set_valid && !busy, req, "R11 done/tlbv/busy",
               {29'b0, done, tlb_set_valid, busy}, 32'h6);
         check({tlb_set_r, tlb_set_c} == fin, req, "R11 new R/C",
               {30'b0, tlb_set_r, tlb_set_c}, {30'b0, fin});
         check(mem[a] == exp_word, req, "R9 word after write", mem[a], exp_word);
         check(rd_cnt == rd0 + 1 && wr_cnt == wr0 + 1, req, "R9 one read one write",
               32'((rd_cnt - rd0) * 16 + (wr_cnt - wr0)), 32'h11);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int dc0, wr0;
      logic [31:0] other;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy, "R11", "reset busy", {31'b0, busy}, 32'h0);
      check(!done, "R11", "reset done", {31'b0, done}, 32'h0);
      check(!mem_req_valid, "R8", "reset mem_req_valid", {31'b0, mem_req_valid}, 32'h0);

      // sweep: each winning flag, alone and with all lower-priority flags (R1)
      for (int k = 0; k <= 11; k++) begin
         for (int ex = 0; ex < 2; ex++) begin
            for (int crc = 0; crc < 4; crc++) begin
               logic [10:0] f;
               f = (k == 11) ? 11'h000 : (11'(1) << k);
               if (ex == 1 && k < 11) f = f | ~((11'(2) << k) - 11'd1);
               run_access(f, 2'(crc), 4'((k * 5 + crc + ex * 3) % 16),
                          (ex == 1) ? "R1" : req_of(k));
            end
         end
      end

      // R3: protection fault with failed conditional store, nothing cached
      run_access(11'h082, 2'b00, 4'd9, "R3");

      // R10: no request carried a different attribute code
      check(attr_bad == 0, "R10", "attribute code", 32'(attr_bad), 32'h0);

      // R11: descriptor presented while busy is ignored
      other = mem[5];
      dc0 = done_cnt;
      wr0 = wr_cnt;
      @(negedge clk);
      acc_flags = 11'h400; acc_tlb_r = 1'b0; acc_tlb_c = 1'b0;
      acc_pte_addr = 8'd3; acc_valid = 1'b1;
      @(negedge clk);
      acc_pte_addr = 8'd5;
      @(negedge clk);
      acc_valid = 1'b0;
      repeat (40) @(negedge clk);
      check(done_cnt == dc0 + 1, "R11", "one completion while busy", 32'(done_cnt - dc0), 32'h1);
      check(wr_cnt == wr0 + 1, "R11", "one write while busy", 32'(wr_cnt - wr0), 32'h1);
      check(mem[5] == other, "R11", "ignored access left word", mem[5], other);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule